// File: doc/BRIEF.md
# Packet Radio SPI Sequencing Controller

This block drives a packet radio transceiver through a separate SPI master. It sits on the master side of a Wishbone bus whose only slave is that SPI master. It performs one bus cycle at a time and walks the SPI master through fixed sequences. The first sequence programs the radio at start-up. A second sequence reads the radio's configuration back so that it can be checked. Other sequences fetch a received payload and load and launch an outgoing one. Between sequences the controller keeps the radio listening. It reacts to the radio's data-ready and address-match pins, which are synchronised to the controller clock before use.

Each SPI exchange follows the same steps. The controller first loads the data words into the SPI master. It then writes the control word with its go bit set. Next it reads the control word repeatedly until the go bit clears, or it waits for the SPI interrupt when the `USE_IRQ` build option is set. Last, it writes zero to the select register, which raises chip select. The three mode pins of the radio hold it in power-down while the controller is idle. They hold it in standby during every bus cycle, in receive while listening, and in transmit while a send is in progress.

States and transitions:
- IDLE goes to DIV on `start_i`.
- The start-up chain runs DIV, CTRL, DAT0, DAT1, DAT2, DAT3, each stepping to the next on a bus acknowledge.
- The shared tail runs GO, BUSY, CSREL. BUSY leaves once the go bit reads back clear. CSREL returns to the state saved when the chain entered GO.
- The read-back chain runs RB_PREP, RB_CMD, then the GO tail, then RB_READ. RB_READ goes to LISTEN.
- In LISTEN, a data-ready rise while address-match is high goes to RX_CMD. Otherwise `tx_req_i` goes to TX_LOAD.
- RX_CMD runs the GO tail and then RX_READ. RX_READ goes back to RB_PREP.
- TX_LOAD runs the GO tail and then TX_FIRE. TX_FIRE goes to LISTEN on a data-ready rise.

Top module: `radio_seq_ctrl`

## Requirements
- R1: After reset the mode pins are all low, `wb_cyc_o`/`wb_stb_o` are low and both valid pulses are low. No bus cycle starts until `start_i` is seen.
- R2: On start the controller performs these writes in this order: divider value to address 5; the control word with `CFG_BITS` to address 4; frame words 0..3 (`cfg_frame_i` slices from the low end) to addresses 0..3; then the same control word with the go bit to address 4. Control word: bit count in [6:0], bit 8 = drive on falling edge (1), bit 10 = interrupt enable (`USE_IRQ`), bit 11 = automatic select (1), bit 12 = go. All other bits are 0.
- R3: A bus cycle keeps cyc, stb, address, write-enable and write data unchanged until ack. The next step starts only after that ack, whatever the ack latency.
- R4: After every go write, the controller reads address 4 until bit 12 returns 0, re-issuing the read while it is 1. It then writes 0 to address 6.
- R5: Read-back writes the control word with `RB_BITS` (no go) and then `RB_CMD` to address 0. It runs the go/poll/release steps with `RB_BITS` and reads address 0. The value read appears on `rb_data_o` with a one-cycle `rb_valid_o`.
- R6: A bus cycle is active only while `rf_trx_ce_o` is 0 and `rf_pwr_up_o` is 1 (standby).
- R7: After read-back the radio is held listening: `rf_pwr_up_o`=1, `rf_trx_ce_o`=1, `rf_tx_en_o`=0.
- R8: While listening, a data-ready rise with address-match high drops `rf_trx_ce_o`. The controller then writes `RX_CMD` to address 0 and runs go/poll/release with `RX_BITS`. It reads address 0 onto `rx_data_o` with a one-cycle `rx_valid_o`, then reruns the read-back sequence.
- R9: A data-ready rise while address-match is low is ignored. No bus cycle starts and the radio stays listening.
- R10: A transmit request while listening captures `tx_payload_i` and writes it to address 0. The controller then runs go/poll/release with `TX_BITS`. Only after that does it raise `rf_tx_en_o` and `rf_trx_ce_o`. It holds them until a data-ready rise, then returns to listening.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin start-up configuration |
| cfg_frame_i | input | 4*DW | Four configuration words for data registers 0..3 |
| tx_req_i | input | 1 | Request a transmission (sampled while listening) |
| tx_payload_i | input | DW | Payload word captured with the request |
| rx_data_o | output | DW | Last fetched received payload |
| rx_valid_o | output | 1 | One-cycle pulse with a new `rx_data_o` |
| rb_data_o | output | DW | Last configuration read-back word |
| rb_valid_o | output | 1 | One-cycle pulse with a new `rb_data_o` |
| rf_dr_i | input | 1 | Radio data-ready pin (asynchronous) |
| rf_am_i | input | 1 | Radio address-match pin (asynchronous) |
| rf_pwr_up_o | output | 1 | Radio power-up mode pin |
| rf_trx_ce_o | output | 1 | Radio transceiver enable pin |
| rf_tx_en_o | output | 1 | Radio transmit-select pin |
| spi_irq_i | input | 1 | SPI master completion interrupt (used when `USE_IRQ`=1) |
| wb_cyc_o | output | 1 | Wishbone cycle |
| wb_stb_o | output | 1 | Wishbone strobe |
| wb_we_o | output | 1 | Wishbone write enable |
| wb_adr_o | output | 3 | Wishbone word address |
| wb_dat_o | output | DW | Wishbone write data |
| wb_dat_i | input | DW | Wishbone read data |
| wb_ack_i | input | 1 | Wishbone acknowledge |

## Verification
The bench's bus slave varies its ack latency from cycle to cycle. A controller that advanced without waiting for ack, or that changed the address under a pending cycle, would log a wrong order or fail the hold check. The slave reports the go bit as busy for two polls. A controller that released chip select after a single poll would produce a shorter, mismatched log. Data-ready is pulsed without address-match to catch a controller that fetches anyway. On transmit, the bench checks that the transmit pins rise only after the select release has been logged, and that they stay up until data-ready.

// File: rtl/radio_seq_pkg.sv
package radio_seq_pkg;

    // word address width of the SPI master register file
    localparam int WB_AW = 3;

    // SPI master register addresses (its decoder depends on these)
    localparam logic [WB_AW-1:0] A_DAT0 = 3'd0;
    localparam logic [WB_AW-1:0] A_DAT1 = 3'd1;
    localparam logic [WB_AW-1:0] A_DAT2 = 3'd2;
    localparam logic [WB_AW-1:0] A_DAT3 = 3'd3;
    localparam logic [WB_AW-1:0] A_CTRL = 3'd4;
    localparam logic [WB_AW-1:0] A_DIV  = 3'd5;
    localparam logic [WB_AW-1:0] A_SEL  = 3'd6;

    // control word fields
    localparam int CB_LEN_W = 7;
    localparam int CB_RXNEG = 7;
    localparam int CB_TXNEG = 8;
    localparam int CB_LSB   = 9;
    localparam int CB_IE    = 10;
    localparam int CB_ASS   = 11;
    localparam int CB_GO    = 12;
    localparam int CW_W     = 32;

    typedef enum logic [4:0] {
        ST_IDLE, ST_DIV, ST_CTRL, ST_DAT0, ST_DAT1, ST_DAT2, ST_DAT3,
        ST_GO, ST_BUSY, ST_CSREL, ST_RB_PREP, ST_RB_CMD, ST_RB_READ,
        ST_LISTEN, ST_RX_CMD, ST_RX_READ, ST_TX_LOAD, ST_TX_FIRE
    } seq_state_e;

    // mode 0 framing: sample on rising, drive on falling, MSB first, auto select
    function automatic logic [CW_W-1:0] ctrl_word(input logic [CB_LEN_W-1:0] nbits,
                                                  input logic irq_en,
                                                  input logic go);
        logic [CW_W-1:0] w;
        w = '0;
        w[CB_LEN_W-1:0] = nbits;
        w[CB_RXNEG] = 1'b0;
        w[CB_TXNEG] = 1'b1;
        w[CB_LSB]   = 1'b0;
        w[CB_IE]    = irq_en;
        w[CB_ASS]   = 1'b1;
        w[CB_GO]    = go;
        return w;
    endfunction

endpackage

// File: rtl/rsc_pin_sync.sv
module rsc_pin_sync #(
    parameter int STAGES = 2,
    parameter bit EDGE   = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic sig_o
);
    logic [STAGES-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-2:0], pin_i};
    end

    generate
        if (EDGE) begin : g_rise
            logic prev_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) prev_q <= 1'b0;
                else        prev_q <= sh_q[STAGES-1];
            end
            assign sig_o = sh_q[STAGES-1] & ~prev_q;
        end else begin : g_level
            assign sig_o = sh_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/rsc_wb_port.sv
module rsc_wb_port #(
    parameter int AW = 3,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_i,
    input  logic          we_i,
    input  logic [AW-1:0] adr_i,
    input  logic [DW-1:0] wdat_i,
    output logic          done_o,
    output logic [DW-1:0] rdat_o,
    output logic          cyc_o,
    output logic          stb_o,
    output logic          we_o,
    output logic [AW-1:0] adr_o,
    output logic [DW-1:0] dat_o,
    input  logic [DW-1:0] dat_i,
    input  logic          ack_i
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_o  <= 1'b0;
            we_o   <= 1'b0;
            adr_o  <= '0;
            dat_o  <= '0;
            done_o <= 1'b0;
            rdat_o <= '0;
        end else if (cyc_o) begin
            if (ack_i) begin
                cyc_o  <= 1'b0;
                done_o <= 1'b1;
                rdat_o <= dat_i;
            end
        end else begin
            done_o <= 1'b0;
            if (req_i && !done_o) begin
                cyc_o <= 1'b1;
                we_o  <= we_i;
                adr_o <= adr_i;
                dat_o <= wdat_i;
            end
        end
    end

    assign stb_o = cyc_o;
endmodule

// File: rtl/radio_seq_ctrl.sv
module radio_seq_ctrl
    import radio_seq_pkg::*;
#(
    parameter int              DW       = 32,
    parameter int              SYNC_STG = 2,
    parameter bit              USE_IRQ  = 1'b0,
    parameter logic [DW-1:0]   DIV_VAL  = 32'd4,
    parameter logic [6:0]      CFG_BITS = 7'd80,
    parameter logic [6:0]      RB_BITS  = 7'd16,
    parameter logic [6:0]      RX_BITS  = 7'd40,
    parameter logic [6:0]      TX_BITS  = 7'd48,
    parameter logic [7:0]      RB_CMD   = 8'h10,
    parameter logic [7:0]      RX_CMD   = 8'h24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [4*DW-1:0]   cfg_frame_i,
    input  logic              tx_req_i,
    input  logic [DW-1:0]     tx_payload_i,
    output logic [DW-1:0]     rx_data_o,
    output logic              rx_valid_o,
    output logic [DW-1:0]     rb_data_o,
    output logic              rb_valid_o,
    input  logic              rf_dr_i,
    input  logic              rf_am_i,
    output logic              rf_pwr_up_o,
    output logic              rf_trx_ce_o,
    output logic              rf_tx_en_o,
    input  logic              spi_irq_i,
    output logic              wb_cyc_o,
    output logic              wb_stb_o,
    output logic              wb_we_o,
    output logic [WB_AW-1:0]  wb_adr_o,
    output logic [DW-1:0]     wb_dat_o,
    input  logic [DW-1:0]     wb_dat_i,
    input  logic              wb_ack_i
);
    seq_state_e st_q, st_d, ret_q, ret_d;
    logic [DW-1:0] pay_q, pay_d;

    logic              bus_req, bus_we, bus_done;
    logic [WB_AW-1:0]  bus_adr;
    logic [DW-1:0]     bus_wdat, bus_rdat;
    logic              dr_rise, am_lvl;
    logic [6:0]        go_bits;

    rsc_pin_sync #(.STAGES(SYNC_STG), .EDGE(1'b1)) u_dr_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(rf_dr_i), .sig_o(dr_rise));

    rsc_pin_sync #(.STAGES(SYNC_STG), .EDGE(1'b0)) u_am_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(rf_am_i), .sig_o(am_lvl));

    rsc_wb_port #(.AW(WB_AW), .DW(DW)) u_port (
        .clk(clk), .rst_n(rst_n),
        .req_i(bus_req), .we_i(bus_we), .adr_i(bus_adr), .wdat_i(bus_wdat),
        .done_o(bus_done), .rdat_o(bus_rdat),
        .cyc_o(wb_cyc_o), .stb_o(wb_stb_o), .we_o(wb_we_o),
        .adr_o(wb_adr_o), .dat_o(wb_dat_o), .dat_i(wb_dat_i), .ack_i(wb_ack_i));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            ret_q <= ST_IDLE;
            pay_q <= '0;
        end else begin
            st_q  <= st_d;
            ret_q <= ret_d;
            pay_q <= pay_d;
        end
    end

    // next state
    always_comb begin
        st_d  = st_q;
        ret_d = ret_q;
        pay_d = pay_q;
        unique case (st_q)
            ST_IDLE:    if (start_i)  st_d = ST_DIV;
            ST_DIV:     if (bus_done) st_d = ST_CTRL;
            ST_CTRL:    if (bus_done) st_d = ST_DAT0;
            ST_DAT0:    if (bus_done) st_d = ST_DAT1;
            ST_DAT1:    if (bus_done) st_d = ST_DAT2;
            ST_DAT2:    if (bus_done) st_d = ST_DAT3;
            ST_DAT3:    if (bus_done) begin st_d = ST_GO; ret_d = ST_RB_PREP; end
            ST_GO:      if (bus_done) st_d = ST_BUSY;
            ST_BUSY: begin
                if (USE_IRQ) begin
                    if (spi_irq_i) st_d = ST_CSREL;
                end else if (bus_done && !bus_rdat[CB_GO]) begin
                    st_d = ST_CSREL;
                end
            end
            ST_CSREL:   if (bus_done) st_d = ret_q;
            ST_RB_PREP: if (bus_done) st_d = ST_RB_CMD;
            ST_RB_CMD:  if (bus_done) begin st_d = ST_GO; ret_d = ST_RB_READ; end
            ST_RB_READ: if (bus_done) st_d = ST_LISTEN;
            ST_LISTEN: begin
                if (dr_rise && am_lvl) begin
                    st_d = ST_RX_CMD;
                end else if (tx_req_i) begin
                    st_d  = ST_TX_LOAD;
                    pay_d = tx_payload_i;
                end
            end
            ST_RX_CMD:  if (bus_done) begin st_d = ST_GO; ret_d = ST_RX_READ; end
            ST_RX_READ: if (bus_done) st_d = ST_RB_PREP;
            ST_TX_LOAD: if (bus_done) begin st_d = ST_GO; ret_d = ST_TX_FIRE; end
            ST_TX_FIRE: if (dr_rise)  st_d = ST_LISTEN;
            default:    st_d = ST_IDLE;
        endcase
    end

    // bit count of the exchange the shared tail is running
    always_comb begin
        unique case (ret_q)
            ST_RB_PREP: go_bits = CFG_BITS;
            ST_RB_READ: go_bits = RB_BITS;
            ST_RX_READ: go_bits = RX_BITS;
            default:    go_bits = TX_BITS;
        endcase
    end

    // outputs
    always_comb begin
        bus_req     = 1'b0;
        bus_we      = 1'b1;
        bus_adr     = A_CTRL;
        bus_wdat    = '0;
        rf_pwr_up_o = 1'b1;
        rf_trx_ce_o = 1'b0;
        rf_tx_en_o  = 1'b0;
        unique case (st_q)
            ST_IDLE:    rf_pwr_up_o = 1'b0;
            ST_DIV:     begin bus_req = 1'b1; bus_adr = A_DIV; bus_wdat = DIV_VAL; end
            ST_CTRL:    begin bus_req = 1'b1; bus_wdat = DW'(ctrl_word(CFG_BITS, USE_IRQ, 1'b0)); end
            ST_DAT0:    begin bus_req = 1'b1; bus_adr = A_DAT0; bus_wdat = cfg_frame_i[0*DW +: DW]; end
            ST_DAT1:    begin bus_req = 1'b1; bus_adr = A_DAT1; bus_wdat = cfg_frame_i[1*DW +: DW]; end
            ST_DAT2:    begin bus_req = 1'b1; bus_adr = A_DAT2; bus_wdat = cfg_frame_i[2*DW +: DW]; end
            ST_DAT3:    begin bus_req = 1'b1; bus_adr = A_DAT3; bus_wdat = cfg_frame_i[3*DW +: DW]; end
            ST_GO:      begin bus_req = 1'b1; bus_wdat = DW'(ctrl_word(go_bits, USE_IRQ, 1'b1)); end
            ST_BUSY:    begin bus_req = !USE_IRQ; bus_we = 1'b0; end
            ST_CSREL:   begin bus_req = 1'b1; bus_adr = A_SEL; end
            ST_RB_PREP: begin bus_req = 1'b1; bus_wdat = DW'(ctrl_word(RB_BITS, USE_IRQ, 1'b0)); end
            ST_RB_CMD:  begin bus_req = 1'b1; bus_adr = A_DAT0; bus_wdat = DW'(RB_CMD); end
            ST_RB_READ: begin bus_req = 1'b1; bus_we = 1'b0; bus_adr = A_DAT0; end
            ST_LISTEN:  rf_trx_ce_o = 1'b1;
            ST_RX_CMD:  begin bus_req = 1'b1; bus_adr = A_DAT0; bus_wdat = DW'(RX_CMD); end
            ST_RX_READ: begin bus_req = 1'b1; bus_we = 1'b0; bus_adr = A_DAT0; end
            ST_TX_LOAD: begin bus_req = 1'b1; bus_adr = A_DAT0; bus_wdat = pay_q; end
            ST_TX_FIRE: begin rf_trx_ce_o = 1'b1; rf_tx_en_o = 1'b1; end
            default:    rf_pwr_up_o = 1'b0;
        endcase
    end

    // captured read results
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data_o  <= '0;
            rx_valid_o <= 1'b0;
            rb_data_o  <= '0;
            rb_valid_o <= 1'b0;
        end else begin
            rx_valid_o <= (st_q == ST_RX_READ) && bus_done;
            rb_valid_o <= (st_q == ST_RB_READ) && bus_done;
            if ((st_q == ST_RX_READ) && bus_done) rx_data_o <= bus_rdat;
            if ((st_q == ST_RB_READ) && bus_done) rb_data_o <= bus_rdat;
        end
    end
endmodule

// File: rtl/rsc_checker.sv
module rsc_checker #(
    parameter int AW = 3,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wb_cyc_o,
    input logic          wb_stb_o,
    input logic          wb_we_o,
    input logic [AW-1:0] wb_adr_o,
    input logic [DW-1:0] wb_dat_o,
    input logic          wb_ack_i,
    input logic          rf_pwr_up_o,
    input logic          rf_trx_ce_o,
    input logic          rf_tx_en_o,
    input logic          rx_valid_o,
    input logic          rb_valid_o
);
    assert_bus_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_stb_o && !wb_ack_i) |=> (wb_stb_o && $stable(wb_adr_o) && $stable(wb_we_o) && $stable(wb_dat_o)));

    assert_spi_in_standby_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wb_cyc_o |-> (!rf_trx_ce_o && rf_pwr_up_o));

    assert_tx_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rf_tx_en_o |-> (rf_trx_ce_o && rf_pwr_up_o));

    assert_rx_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |=> !rx_valid_o);

    assert_rb_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rb_valid_o |=> !rb_valid_o);

    assert_powerdown_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !rf_pwr_up_o |-> (!rf_trx_ce_o && !wb_cyc_o));
endmodule

bind radio_seq_ctrl rsc_checker #(.AW(radio_seq_pkg::WB_AW), .DW(DW)) u_chk (.*);

// File: tb/tb_radio_seq_ctrl.sv
module tb_radio_seq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;
    localparam logic [31:0] P_DIV = 32'd4;
    localparam int B_CFG = 80, B_RB = 16, B_RX = 40, B_TX = 48;
    localparam logic [7:0] C_RB = 8'h10, C_RX = 8'h24;
    localparam int POLLS = 2;
    localparam logic [31:0] F0 = 32'h1122_3344, F1 = 32'h5566_7788,
                            F2 = 32'h99AA_BBCC, F3 = 32'hDDEE_FF01;

    function automatic logic [31:0] cw(input int bits, input bit go);
        return 32'(bits) | 32'h0000_0100 | 32'h0000_0800 | (go ? 32'h0000_1000 : 32'h0);
    endfunction
    function automatic logic [35:0] ent(input bit we, input int adr, input logic [31:0] d);
        return {we, 3'(adr), d};
    endfunction

    localparam logic [35:0] CFG_SEQ [19] = '{
        ent(1, 5, P_DIV), ent(1, 4, cw(B_CFG, 0)),
        ent(1, 0, F0), ent(1, 1, F1), ent(1, 2, F2), ent(1, 3, F3),
        ent(1, 4, cw(B_CFG, 1)), ent(0, 4, 0), ent(0, 4, 0), ent(0, 4, 0),
        ent(1, 6, 0),
        ent(1, 4, cw(B_RB, 0)), ent(1, 0, 32'(C_RB)), ent(1, 4, cw(B_RB, 1)),
        ent(0, 4, 0), ent(0, 4, 0), ent(0, 4, 0), ent(1, 6, 0), ent(0, 0, 0)
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, tx_req = 1'b0, dr = 1'b0, am = 1'b0;
    logic [4*DW-1:0] frame;
    logic [DW-1:0] payload = '0;
    logic [DW-1:0] rx_data, rb_data;
    logic rx_valid, rb_valid, pwr_up, trx_ce, tx_en;
    logic cyc, stb, we, ack;
    logic [2:0] adr;
    logic [DW-1:0] wdat, rdat;

    always #(CLK_PERIOD/2) clk = ~clk;

    radio_seq_ctrl #(
        .DW(DW), .USE_IRQ(1'b0), .DIV_VAL(P_DIV),
        .CFG_BITS(7'(B_CFG)), .RB_BITS(7'(B_RB)), .RX_BITS(7'(B_RX)), .TX_BITS(7'(B_TX)),
        .RB_CMD(C_RB), .RX_CMD(C_RX)
    ) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .cfg_frame_i(frame),
        .tx_req_i(tx_req), .tx_payload_i(payload),
        .rx_data_o(rx_data), .rx_valid_o(rx_valid), .rb_data_o(rb_data), .rb_valid_o(rb_valid),
        .rf_dr_i(dr), .rf_am_i(am), .rf_pwr_up_o(pwr_up), .rf_trx_ce_o(trx_ce), .rf_tx_en_o(tx_en),
        .spi_irq_i(1'b0),
        .wb_cyc_o(cyc), .wb_stb_o(stb), .wb_we_o(we), .wb_adr_o(adr), .wb_dat_o(wdat),
        .wb_dat_i(rdat), .wb_ack_i(ack));

    // bus slave model with varying ack latency and a busy go bit
    logic        log_we  [64];
    logic [2:0]  log_adr [64];
    logic [31:0] log_dat [64];
    int nlog, wcnt, busy, stab_err, viol, rx_seen;
    logic [31:0] rd0_val = 32'h0BAD_0001;
    logic [2:0]  h_adr;
    logic [31:0] h_dat;
    logic        h_we;

    always @(posedge clk) begin
        if (!rst_n) begin
            ack <= 1'b0; wcnt <= 0; nlog <= 0; busy <= 0; stab_err <= 0; rdat <= '0;
        end else begin
            ack <= 1'b0;
            if (stb && !ack) begin
                if (wcnt == 0) begin
                    h_adr <= adr; h_dat <= wdat; h_we <= we;
                end else if (adr != h_adr || wdat != h_dat || we != h_we) begin
                    stab_err <= stab_err + 1;
                end
                if (wcnt == nlog % 3) begin
                    ack <= 1'b1; wcnt <= 0;
                    if (nlog < 64) begin
                        log_we[nlog] <= we; log_adr[nlog] <= adr;
                        log_dat[nlog] <= we ? wdat : 32'h0;
                    end
                    nlog <= nlog + 1;
                    if (we && adr == 3'd4 && wdat[12]) busy <= POLLS;
                    if (!we) begin
                        if (adr == 3'd4) begin
                            rdat <= (busy != 0) ? 32'h0000_1000 : 32'h0;
                            if (busy != 0) busy <= busy - 1;
                        end else if (adr == 3'd0) rdat <= rd0_val;
                        else rdat <= '0;
                    end
                end else begin
                    wcnt <= wcnt + 1;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (!rst_n) begin
            viol <= 0; rx_seen <= 0;
        end else begin
            if (cyc && (trx_ce || !pwr_up)) viol <= viol + 1;
            if (rx_valid) rx_seen <= rx_seen + 1;
        end
    end

    int checks = 0, errors = 0;
    bit done_flag = 1'b0;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_log(input int idx, input logic [35:0] exp, input string tag);
        logic [35:0] act;
        act = (idx < 64) ? {log_we[idx], log_adr[idx], log_dat[idx]} : 36'h0;
        check(act == exp, tag, 64'(act), 64'(exp));
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        int base;
        int t;
        frame = {F3, F2, F1, F0};
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state and idle without start
        check({pwr_up, trx_ce, tx_en} == 3'b000, "R1 mode pins after reset", 64'({pwr_up, trx_ce, tx_en}), 64'h0);
        check({cyc, stb, rx_valid, rb_valid} == 4'b0, "R1 bus and valids after reset", 64'({cyc, stb, rx_valid, rb_valid}), 64'h0);
        repeat (10) @(negedge clk);
        check(nlog == 0, "R1 no bus cycle before start", 64'(nlog), 64'h0);

        // R2 R4 R5: start-up and read-back sequence
        start = 1'b1; @(negedge clk); start = 1'b0;
        t = 0;
        while (!rb_valid && t < 3000) begin @(negedge clk); t++; end
        check(rb_valid == 1'b1, "R5 read-back pulse", 64'(rb_valid), 64'h1);
        check(rb_data == 32'h0BAD_0001, "R5 read-back data", 64'(rb_data), 64'h0BAD_0001);
        check(nlog == 19, "R2 R4 R5 bus cycle count", 64'(nlog), 64'd19);
        for (int i = 0; i < 19; i++) chk_log(i, CFG_SEQ[i], "R2 R4 R5 sequence entry");
        // R7: listening
        check({pwr_up, trx_ce, tx_en} == 3'b110, "R7 listen mode pins", 64'({pwr_up, trx_ce, tx_en}), 64'h6);

        // R9: data-ready without address match
        repeat (3) @(negedge clk);
        base = nlog;
        dr = 1'b1; am = 1'b0;
        repeat (3) @(negedge clk);
        dr = 1'b0;
        repeat (20) @(negedge clk);
        check(nlog == base, "R9 no bus cycle on DR without AM", 64'(nlog), 64'(base));
        check(trx_ce == 1'b1 && rx_seen == 0, "R9 still listening", 64'({trx_ce, 8'(rx_seen)}), 64'h100);

        // R8: receive
        rd0_val = 32'hA5C3_0F17;
        base = nlog;
        dr = 1'b1; am = 1'b1;
        t = 0;
        while (!rx_valid && t < 3000) begin @(negedge clk); t++; end
        check(rx_data == 32'hA5C3_0F17, "R8 received payload", 64'(rx_data), 64'hA5C3_0F17);
        chk_log(base + 0, ent(1, 0, 32'(C_RX)), "R8 receive command");
        chk_log(base + 1, ent(1, 4, cw(B_RX, 1)), "R8 receive go word");
        chk_log(base + 4, ent(0, 4, 0), "R8 R4 last poll");
        chk_log(base + 5, ent(1, 6, 0), "R8 select release");
        chk_log(base + 6, ent(0, 0, 0), "R8 payload read");
        dr = 1'b0; am = 1'b0;
        t = 0;
        while (!rb_valid && t < 3000) begin @(negedge clk); t++; end
        check(rb_valid == 1'b1, "R8 read-back rerun", 64'(rb_valid), 64'h1);
        chk_log(base + 7, ent(1, 4, cw(B_RB, 0)), "R8 loops to read-back prep");
        check(nlog == base + 15, "R8 cycle count", 64'(nlog), 64'(base + 15));
        check(trx_ce == 1'b1 && tx_en == 1'b0, "R8 R7 back to listen", 64'({trx_ce, tx_en}), 64'h2);

        // R10: transmit
        repeat (3) @(negedge clk);
        base = nlog;
        payload = 32'hCAFE_B0BA;
        tx_req = 1'b1; @(negedge clk); tx_req = 1'b0; payload = 32'h0;
        t = 0;
        while (!tx_en && t < 3000) begin @(negedge clk); t++; end
        check(nlog == base + 6, "R10 send pins only after release", 64'(nlog), 64'(base + 6));
        chk_log(base + 0, ent(1, 0, 32'hCAFE_B0BA), "R10 payload write");
        chk_log(base + 1, ent(1, 4, cw(B_TX, 1)), "R10 transmit go word");
        chk_log(base + 5, ent(1, 6, 0), "R10 select release");
        check({pwr_up, trx_ce, tx_en, cyc} == 4'b1110, "R10 send mode", 64'({pwr_up, trx_ce, tx_en, cyc}), 64'hE);
        repeat (10) @(negedge clk);
        check(tx_en == 1'b1, "R10 held until data-ready", 64'(tx_en), 64'h1);
        dr = 1'b1;
        t = 0;
        while (tx_en && t < 100) begin @(negedge clk); t++; end
        check({trx_ce, tx_en} == 2'b10, "R10 returns to listen", 64'({trx_ce, tx_en}), 64'h2);
        check(nlog == base + 6, "R10 no bus cycle after send", 64'(nlog), 64'(base + 6));
        dr = 1'b0;
        repeat (5) @(negedge clk);

        check(viol == 0, "R6 bus only in standby", 64'(viol), 64'h0);
        check(stab_err == 0, "R3 bus held until ack", 64'(stab_err), 64'h0);
        finish_run();
    end
endmodule